// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches thirteen general-purpose input pins that are split into two groups: eight pins in group 0 and five pins in group 1. Whenever an enabled pin in a group moves from low to high or from high to low, the block sets a single pending flag for that group. When the flag, the group enable and a global interrupt-enable input are all high, the block raises that group's request line toward an interrupt arbiter.

Software uses a small synchronous register bus to set the per-pin masks and the group enables, and to read and clear the pending flags. A flag is cleared in one of two ways. Software can write a one to the flag bit. The hardware also clears it when the arbiter pulses the acknowledge strobe for that group. The pin inputs must already be synchronized to the block clock.

Top module: `pcx_pin_change_ctrl`

## Requirements
- R1: When a pin's mask bit and its group's enable bit are both one, and the pin's level differs from the level sampled on the previous clock (a rising or a falling change), the group's pending flag is one after that clock edge.
- R2: A change on a pin whose mask bit is zero never sets its group's pending flag.
- R3: While a group's enable bit is zero, no pin change sets that group's pending flag.
- R4: irq_req[g] is one exactly when group g's pending flag, group g's enable bit and glb_irq_en are all one. It follows them combinationally.
- R5: A one on irq_ack[g] clears group g's pending flag at that clock edge.
- R6: A bus write of data d to address 3 clears pending flag g wherever d[g] is one. A flag whose data bit is zero keeps its value.
- R7: If a qualifying change (R1) arrives in the same cycle as a clear from R5 or R6, the flag is one after the edge.
- R8: Register map, with read data combinational on bus_addr. Address 0 holds the group-0 mask, 8 bits, read/write, bit i for pins_g0[i]. Address 1 holds the group-1 mask in bits 4..0, bit i for pins_g1[i]; bits 7..5 always read zero. Address 2 holds the group enables and address 3 the pending flags. In both of these, bit 0 is group 0, bit 1 is group 1, and bits 7..2 read zero.
- R9: Synchronous reset clears both masks, the enables and the flags. While reset is high the previous-level register copies the pins, so pin activity during reset sets no flag.
- R10: The two groups are independent. Changes, clears and acknowledges for one group leave the other group's flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address for both read and write |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pins_g0 | input | 8 | Synchronized group-0 pins |
| pins_g1 | input | 5 | Synchronized group-1 pins |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq_ack | input | 2 | Per-group acknowledge strobe (bit 0 is group 0) |
| irq_req | output | 2 | Per-group interrupt request (bit 0 is group 0) |

## Verification
A flag can be set and cleared in the same cycle. This happens when a masked pin toggles on the same edge that the arbiter acknowledges the group, or on the same edge that software writes a one to the flag register. The bench produces both cases on purpose in directed steps. In the directed steps the flag is already one, the clear request is applied, and the pin is toggled in that same cycle. After the edge the flag must still read one. The random phase later mixes acknowledges, flag writes and pin activity freely. In that phase a behavioural model, which applies the rule that a set wins over a clear, is compared against the request lines and the read data on every clock.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int NUM_GRP = 2;
    localparam int G0_PINS = 8;
    localparam int G1_PINS = 5;

    typedef enum logic [ADDR_W-1:0] {
        REG_MASK0 = 2'd0,
        REG_MASK1 = 2'd1,
        REG_GEN   = 2'd2,
        REG_FLAG  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              we;
        reg_addr_e         addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    typedef logic [NUM_GRP-1:0][DATA_W-1:0] grp_vec_t;

    function automatic logic [DATA_W-1:0] zext_grp(input logic [NUM_GRP-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[NUM_GRP-1:0] = v;
        return r;
    endfunction
endpackage

// File: rtl/pcx_change_det.sv
module pcx_change_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] pins,
    output logic [W-1:0] chg
);
    logic [W-1:0] prev_q;

    // Tracks the pins during reset too, so no false change appears afterwards.
    always_ff @(posedge clk) begin
        prev_q <= pins;
    end

    assign chg = pins ^ prev_q;
endmodule

// File: rtl/pcx_flag_cell.sv
module pcx_flag_cell #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] chg,
    input  logic [W-1:0] mask,
    input  logic         grp_en,
    input  logic         glb_en,
    input  logic         ack,
    input  logic         w1c,
    output logic         flag,
    output logic         req
);
    logic hit;
    logic clr;
    logic flag_q;

    assign hit = grp_en & (|(chg & mask));
    assign clr = ack | w1c;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= hit | (flag_q & ~clr);
        end
    end

    assign flag = flag_q;
    assign req  = flag_q & grp_en & glb_en;

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);
    assert_mask_gate_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(|(chg & mask)));
    assert_en_gate_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(grp_en));
    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (ack && !hit) |=> !flag_q);
    assert_w1c_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (w1c && !hit) |=> !flag_q);
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !ack && !w1c) |=> flag_q);
endmodule

// File: rtl/pcx_regs.sv
module pcx_regs
    import pcx_pkg::*;
#(
    parameter int G0_W = G0_PINS,
    parameter int G1_W = G1_PINS
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_wr_t             wr,
    input  logic [NUM_GRP-1:0]  flags,
    output grp_vec_t            grp_mask,
    output logic [NUM_GRP-1:0]  grp_en,
    output logic [NUM_GRP-1:0]  w1c,
    output logic [DATA_W-1:0]   rdata
);
    logic [G0_W-1:0]    mask0_q;
    logic [G1_W-1:0]    mask1_q;
    logic [NUM_GRP-1:0] gen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask0_q <= '0;
            mask1_q <= '0;
            gen_q   <= '0;
        end else if (wr.we) begin
            case (wr.addr)
                REG_MASK0: mask0_q <= wr.data[G0_W-1:0];
                REG_MASK1: mask1_q <= wr.data[G1_W-1:0];
                REG_GEN:   gen_q   <= wr.data[NUM_GRP-1:0];
                default:   ;
            endcase
        end
    end

    assign w1c    = (wr.we && wr.addr == REG_FLAG) ? wr.data[NUM_GRP-1:0] : '0;
    assign grp_en = gen_q;

    always_comb begin
        grp_mask = '0;
        grp_mask[0][G0_W-1:0] = mask0_q;
        grp_mask[1][G1_W-1:0] = mask1_q;
    end

    always_comb begin
        rdata = '0;
        case (wr.addr)
            REG_MASK0: rdata[G0_W-1:0] = mask0_q;
            REG_MASK1: rdata[G1_W-1:0] = mask1_q;
            REG_GEN:   rdata = zext_grp(gen_q);
            default:   rdata = zext_grp(flags);
        endcase
    end

    assert_mask1_upper_R8: assert property (@(posedge clk) disable iff (rst)
        (wr.addr == REG_MASK1) |-> (rdata[DATA_W-1:G1_W] == '0));
    assert_mask_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr.we && wr.addr == REG_MASK0) |=> (grp_mask[0][G0_W-1:0] == $past(wr.data[G0_W-1:0])));
endmodule

// File: rtl/pcx_pin_change_ctrl.sv
module pcx_pin_change_ctrl
    import pcx_pkg::*;
#(
    parameter int G0_W = G0_PINS,
    parameter int G1_W = G1_PINS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [G0_W-1:0]             pins_g0,
    input  logic [G1_W-1:0]             pins_g1,
    input  logic                        glb_irq_en,
    input  logic [NUM_GRP-1:0]          irq_ack,
    output logic [NUM_GRP-1:0]          irq_req
);
    bus_wr_t            wr;
    grp_vec_t           pins_pad;
    grp_vec_t           grp_mask;
    logic [NUM_GRP-1:0] grp_en;
    logic [NUM_GRP-1:0] w1c;
    logic [NUM_GRP-1:0] flags;

    assign wr.we   = bus_we;
    assign wr.addr = reg_addr_e'(bus_addr);
    assign wr.data = bus_wdata;

    always_comb begin
        pins_pad = '0;
        pins_pad[0][G0_W-1:0] = pins_g0;
        pins_pad[1][G1_W-1:0] = pins_g1;
    end

    pcx_regs #(.G0_W(G0_W), .G1_W(G1_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .flags    (flags),
        .grp_mask (grp_mask),
        .grp_en   (grp_en),
        .w1c      (w1c),
        .rdata    (bus_rdata)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [DATA_W-1:0] chg;

        pcx_change_det #(.W(DATA_W)) det_i (
            .clk  (clk),
            .pins (pins_pad[g]),
            .chg  (chg)
        );

        pcx_flag_cell #(.W(DATA_W)) cell_i (
            .clk    (clk),
            .rst    (rst),
            .chg    (chg),
            .mask   (grp_mask[g]),
            .grp_en (grp_en[g]),
            .glb_en (glb_irq_en),
            .ack    (irq_ack[g]),
            .w1c    (w1c[g]),
            .flag   (flags[g]),
            .req    (irq_req[g])
        );
    end

    assert_glb_gate_R4: assert property (@(posedge clk) disable iff (rst)
        !glb_irq_en |-> (irq_req == '0));
    assert_grp_indep_R10: assert property (@(posedge clk) disable iff (rst)
        (!irq_ack[1] && !w1c[1] && (pins_g1 == $past(pins_g1))) |=> (flags[1] == $past(flags[1])));
endmodule

// File: tb/pcx_pin_change_ctrl_tb_top.sv
`timescale 1ns/1ps
module pcx_pin_change_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] pins_g0 = 8'h3C;
    logic [4:0] pins_g1 = 5'h05;
    logic       glb_irq_en = 1'b0;
    logic [1:0] irq_ack = 2'b00;
    logic [1:0] irq_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pcx_pin_change_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_g0(pins_g0),
        .pins_g1(pins_g1), .glb_irq_en(glb_irq_en), .irq_ack(irq_ack),
        .irq_req(irq_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [7:0] m_mask0;
    logic [4:0] m_mask1;
    logic [1:0] m_gen, m_flag, m_clr;
    logic [7:0] m_prev0;
    logic [4:0] m_prev1;
    bit         m_hit0, m_hit1;

    always @(posedge clk) begin
        if (rst) begin
            m_mask0 = 0; m_mask1 = 0; m_gen = 0; m_flag = 0;
        end else begin
            m_hit0 = m_gen[0] && (|((pins_g0 ^ m_prev0) & m_mask0));
            m_hit1 = m_gen[1] && (|((pins_g1 ^ m_prev1) & m_mask1));
            m_clr  = irq_ack | ((bus_we && bus_addr == 2'd3) ? bus_wdata[1:0] : 2'b00);
            m_flag[0] = m_hit0 || (m_flag[0] && !m_clr[0]);
            m_flag[1] = m_hit1 || (m_flag[1] && !m_clr[1]);
            if (bus_we) begin
                case (bus_addr)
                    2'd0: m_mask0 = bus_wdata;
                    2'd1: m_mask1 = bus_wdata[4:0];
                    2'd2: m_gen   = bus_wdata[1:0];
                    default: ;
                endcase
            end
        end
        m_prev0 = pins_g0;
        m_prev1 = pins_g1;
    end

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_mask0;
            2'd1: return {3'b000, m_mask1};
            2'd2: return {6'd0, m_gen};
            default: return {6'd0, m_flag};
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(irq_req === (m_flag & m_gen & {2{glb_irq_en}}), "R4 model irq_req", irq_req,
                m_flag & m_gen & {2{glb_irq_en}});
            chk(bus_rdata === exp_rd(bus_addr), "R8 model rdata", bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string req);
        bus_addr = a;
        #1;
        chk(bus_rdata === e, req, bus_rdata, e);
    endtask

    initial begin
        step();
        pins_g0 = 8'hC3; pins_g1 = 5'h1A;
        step();
        pins_g0 = 8'h00;
        step();
        rst = 1'b0;
        step();
        // R9: reset values, no flags from activity during reset
        rd_chk(2'd0, 8'h00, "R9 mask0 reset");
        rd_chk(2'd1, 8'h00, "R9 mask1 reset");
        rd_chk(2'd2, 8'h00, "R9 enable reset");
        rd_chk(2'd3, 8'h00, "R9 flag reset");
        chk(irq_req === 2'b00, "R9 irq_req reset", irq_req, 0);

        // R8: register map and read-only upper bits of mask1
        wr(2'd1, 8'hFF);
        rd_chk(2'd1, 8'h1F, "R8 mask1 upper bits read zero");
        wr(2'd0, 8'hA5);
        rd_chk(2'd0, 8'hA5, "R8 mask0 readback");
        wr(2'd2, 8'hFF);
        rd_chk(2'd2, 8'h03, "R8 enable upper bits read zero");
        glb_irq_en = 1'b1;

        // R1: rising change on masked pin 0 of group 0
        pins_g0 = 8'h01;
        step();
        rd_chk(2'd3, 8'h01, "R1 rising change sets flag0");
        chk(irq_req === 2'b01, "R4 request follows flag0", irq_req, 1);
        // R6: write-one clears
        wr(2'd3, 8'h01);
        rd_chk(2'd3, 8'h00, "R6 write one clears flag0");
        // R1: falling change
        pins_g0 = 8'h00;
        step();
        rd_chk(2'd3, 8'h01, "R1 falling change sets flag0");
        // R6: write zero keeps
        wr(2'd3, 8'h00);
        rd_chk(2'd3, 8'h01, "R6 write zero keeps flag0");
        // R5: acknowledge clears
        irq_ack = 2'b01;
        step();
        irq_ack = 2'b00;
        rd_chk(2'd3, 8'h00, "R5 ack clears flag0");

        // R2: unmasked pin 1 (mask0 bit1 = 0)
        pins_g0 = 8'h02;
        step();
        step();
        rd_chk(2'd3, 8'h00, "R2 unmasked pin ignored");

        // R3: group 1 disabled
        wr(2'd2, 8'h01);
        pins_g1 = 5'h1B;
        step();
        rd_chk(2'd3, 8'h00, "R3 disabled group not flagged");
        wr(2'd2, 8'h03);
        pins_g1 = 5'h1A;
        step();
        rd_chk(2'd3, 8'h02, "R10 group1 flag only, group0 untouched");
        glb_irq_en = 1'b0;
        #1;
        chk(irq_req === 2'b00, "R4 global enable masks request", irq_req, 0);
        rd_chk(2'd3, 8'h02, "R4 flag held while globally masked");
        glb_irq_en = 1'b1;

        // R7: change and ack in same cycle
        pins_g1 = 5'h1B; irq_ack = 2'b10;
        step();
        irq_ack = 2'b00;
        rd_chk(2'd3, 8'h02, "R7 set beats ack clear");
        // R7: change and write-one in same cycle
        pins_g1 = 5'h1A; bus_addr = 2'd3; bus_wdata = 8'h02; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
        rd_chk(2'd3, 8'h02, "R7 set beats write-one clear");
        // R10: ack of group 0 leaves group 1
        irq_ack = 2'b01;
        step();
        irq_ack = 2'b00;
        rd_chk(2'd3, 8'h02, "R10 ack0 leaves flag1");

        // Random phase against model
        for (int i = 0; i < 600; i++) begin
            pins_g0 = ($urandom % 4 == 0) ? 8'($urandom) : pins_g0;
            pins_g1 = ($urandom % 4 == 0) ? 5'($urandom) : pins_g1;
            irq_ack = ($urandom % 6 == 0) ? 2'($urandom) : 2'b00;
            glb_irq_en = ($urandom % 8 != 0);
            bus_addr = 2'($urandom);
            bus_wdata = 8'($urandom);
            bus_we = ($urandom % 6 == 0);
            step();
        end
        bus_we = 1'b0;
        irq_ack = 2'b00;
        step();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule